// File: doc/BRIEF.md
# Addressed Serial Control Port

This block is the control port of a two-channel image front end. A host shifts 16-bit frames in over three wires: a serial data line, a shift clock and a write strobe. Each frame names a target device, a register and a data word. Several devices can share the same three wires. Each device answers only to frames whose device field equals its two strap inputs. Accepted writes land in a small register file. Every field of that file is presented in parallel to the datapath: the clamp polarities, the channel output order, the output delay step, standby, the two channel gains, the two black-level codes and the test-pattern controls.

A frame can also ask for a register to be returned. In that case the selected register is loaded into a 10-bit return shifter. After the strobe, the host holds the strobe low and pulses the shift clock to collect the register on the serial output. While that transfer is under way, any further strobe is refused. All serial inputs are sampled on the block clock and are assumed to be already synchronous to it. An asynchronous active-low reset restores every register to its power-on value.

Top module: `sir_ctrl_port`

## Requirements
- R1: On each rising edge of `ser_clk`, the level on `ser_din` enters the frame shifter. A frame is 16 bits sent MSB first: bits [15:14] are the device field, bits [13:10] the register command and bits [9:0] the data. The frame is acted on at the rising edge of `ser_strobe`.
- R2: When more than 16 bits are shifted before a strobe, only the last 16 bits count.
- R3: A write takes effect only when the device field equals `dev_strap`. A mismatched frame leaves every register unchanged.
- R4: Register map, selected by command bits [2:0] with command bit 3 = 0. Register 0 holds `inclamp_pol` in bit 0, `blkclamp_pol` in bit 1, `samp_pol` in bit 2, `odd_first` in bit 4 and `out_dly` in bits 7:6. Register 1 holds `standby` in bit 0. Registers 2 and 3 hold `gain_even` and `gain_odd` in bits 9:0. Registers 4 and 5 hold `black_even` and `black_odd` in bits 7:0. Register 6 holds `test_en` in bit 0, `test_stripe` in bit 2 and `test_interval` in bits 5:4. A write to register 7 changes nothing.
- R5: After reset, registers 2 and 3 hold 64, registers 4 and 5 hold 80, and every other field is 0.
- R6: A frame with command bit 3 = 1 and a matching device field is a read of the register named by command bits [2:0]. From the strobe edge on, `ser_dout` shows register bit 9. Each following `ser_clk` rising edge advances one bit toward bit 0. After the tenth such edge, `ser_dout` returns low.
- R7: While a read transfer is in progress, a strobe is ignored. Any write frame it carries leaves the registers unchanged, and the transfer continues.
- R8: A read frame whose device field does not match `dev_strap` is ignored, and `ser_dout` stays low.
- R9: Bits that a register does not define read back as 0, whatever was written to them. Register 7 reads as all zeros.
- R10: `ser_dout` is low whenever no read transfer is in progress.
- R11: Driving `rst_n` low restores the R5 values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock, acts on its rising edge |
| ser_din | input | 1 | Serial frame data, MSB first |
| ser_strobe | input | 1 | Frame strobe, acts on its rising edge |
| dev_strap | input | 2 | Device address this port answers to |
| ser_dout | output | 1 | Serial read-back data |
| inclamp_pol | output | 1 | Input clamp pulse polarity |
| blkclamp_pol | output | 1 | Black clamp pulse polarity |
| samp_pol | output | 1 | Sampling pulse polarity |
| odd_first | output | 1 | Channel output order, 1 = odd channel first |
| out_dly | output | 2 | Output data delay step |
| standby | output | 1 | Standby request |
| gain_even | output | 10 | Even channel gain code |
| gain_odd | output | 10 | Odd channel gain code |
| black_even | output | 8 | Even channel black-level code |
| black_odd | output | 8 | Odd channel black-level code |
| test_en | output | 1 | Test pattern enable |
| test_stripe | output | 1 | Test pattern kind, 1 = stripe |
| test_interval | output | 2 | Test pattern interval step |

## Verification
The bench uses the package defaults: a 2-bit device field, a 4-bit command and a 10-bit data word. The 2-bit device field is small enough that the bench moves the strap through more than one value and sends frames addressed to every other device. The 3-bit register select lets random frames reach all eight registers, including the reserved one, within a few dozen frames. The 10-bit return shifter is short enough that the bench can build a read frame whose tail turns into a write frame part-way through the transfer. That write frame is then strobed one bit before the transfer ends.

// File: rtl/sir_pkg.sv
package sir_pkg;
    localparam int DEV_W   = 2;
    localparam int CMD_W   = 4;
    localparam int DW      = 10;
    localparam int FRAME_W = DEV_W + CMD_W + DW;
    localparam int SEL_W   = CMD_W - 1;
    localparam int NREG    = 1 << SEL_W;
    localparam int CNT_W   = $clog2(DW + 1);

    // Bits each register actually keeps.
    function automatic logic [DW-1:0] field_mask(input logic [SEL_W-1:0] idx);
        case (idx)
            3'd0:       return DW'(10'h0D7);
            3'd1:       return DW'(10'h001);
            3'd2, 3'd3: return DW'(10'h3FF);
            3'd4, 3'd5: return DW'(10'h0FF);
            3'd6:       return DW'(10'h035);
            default:    return '0;
        endcase
    endfunction

    // Power-on value of each register.
    function automatic logic [DW-1:0] reset_value(input logic [SEL_W-1:0] idx);
        case (idx)
            3'd2, 3'd3: return DW'(64);
            3'd4, 3'd5: return DW'(80);
            default:    return '0;
        endcase
    endfunction
endpackage

// File: rtl/sir_shift.sv
module sir_shift
    import sir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame_o
);
    logic [FRAME_W-1:0] frame_d, frame_q;

    always_comb begin
        frame_d = frame_q;
        if (shift_en) frame_d = {frame_q[FRAME_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_q <= '0;
        else        frame_q <= frame_d;
    end

    assign frame_o = frame_q;

    // R1: the newest serial bit lands in the LSB
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame_o[0] == $past(bit_in));
endmodule

// File: rtl/sir_regfile.sv
module sir_regfile
    import sir_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [DW-1:0]             wr_data,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [DW-1:0]             rd_data,
    output logic [NREG-1:0][DW-1:0]   regs_o
);
    logic [NREG-1:0][DW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[wr_sel] = wr_data & field_mask(wr_sel);
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= reset_value(SEL_W'(g));
            else        regs_q[g] <= regs_d[g];
        end
    end

    assign rd_data = regs_q[rd_sel];
    assign regs_o  = regs_q;

    // R9: undefined bits never read back as one
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~field_mask(rd_sel)) == '0);
endmodule

// File: rtl/sir_readout.sv
module sir_readout
    import sir_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          shift_en,
    output logic          busy,
    output logic          dout
);
    typedef struct packed {
        logic [DW-1:0]    sh;
        logic [CNT_W-1:0] cnt;
    } ro_t;

    ro_t ro_d, ro_q;

    always_comb begin
        ro_d = ro_q;
        if (load) begin
            ro_d.sh  = load_data;
            ro_d.cnt = CNT_W'(DW);
        end else if (shift_en && ro_q.cnt != '0) begin
            ro_d.sh  = {ro_q.sh[DW-2:0], 1'b0};
            ro_d.cnt = ro_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ro_q <= '0;
        else        ro_q <= ro_d;
    end

    assign busy = (ro_q.cnt != '0);
    assign dout = busy & ro_q.sh[DW-1];

    // R6: the MSB is presented right after the load
    p_first_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && dout == $past(load_data[DW-1])));
    // R10: idle output is low
    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dout);
endmodule

// File: rtl/sir_ctrl_port.sv
module sir_ctrl_port
    import sir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_din,
    input  logic        ser_strobe,
    input  logic [1:0]  dev_strap,
    output logic        ser_dout,
    output logic        inclamp_pol,
    output logic        blkclamp_pol,
    output logic        samp_pol,
    output logic        odd_first,
    output logic [1:0]  out_dly,
    output logic        standby,
    output logic [9:0]  gain_even,
    output logic [9:0]  gain_odd,
    output logic [7:0]  black_even,
    output logic [7:0]  black_odd,
    output logic        test_en,
    output logic        test_stripe,
    output logic [1:0]  test_interval
);
    typedef struct packed {
        logic sclk;
        logic strb;
    } edge_t;

    edge_t ed_d, ed_q;

    logic                    sclk_rise, strb_rise;
    logic [FRAME_W-1:0]      frame;
    logic                    dev_match, is_read, rd_busy;
    logic [SEL_W-1:0]        sel;
    logic [DW-1:0]           rd_data;
    logic [NREG-1:0][DW-1:0] regs;
    logic                    wr_en, rd_load;

    always_comb begin
        ed_d.sclk = ser_clk;
        ed_d.strb = ser_strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign sclk_rise = ser_clk & ~ed_q.sclk;
    assign strb_rise = ser_strobe & ~ed_q.strb;

    sir_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(sclk_rise),
        .bit_in  (ser_din),
        .frame_o (frame)
    );

    assign dev_match = (frame[FRAME_W-1 -: DEV_W] == dev_strap);
    assign is_read   = frame[DW + CMD_W - 1];
    assign sel       = frame[DW +: SEL_W];
    assign wr_en     = strb_rise & dev_match & ~is_read & ~rd_busy;
    assign rd_load   = strb_rise & dev_match &  is_read & ~rd_busy;

    sir_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (sel),
        .wr_data(frame[DW-1:0]),
        .rd_sel (sel),
        .rd_data(rd_data),
        .regs_o (regs)
    );

    sir_readout u_ro (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_load),
        .load_data(rd_data),
        .shift_en (sclk_rise),
        .busy     (rd_busy),
        .dout     (ser_dout)
    );

    assign inclamp_pol   = regs[0][0];
    assign blkclamp_pol  = regs[0][1];
    assign samp_pol      = regs[0][2];
    assign odd_first     = regs[0][4];
    assign out_dly       = regs[0][7:6];
    assign standby       = regs[1][0];
    assign gain_even     = regs[2];
    assign gain_odd      = regs[3];
    assign black_even    = regs[4][7:0];
    assign black_odd     = regs[5][7:0];
    assign test_en       = regs[6][0];
    assign test_stripe   = regs[6][2];
    assign test_interval = regs[6][5:4];

    // R3: a frame for another device leaves the file untouched
    p_foreign_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_rise && !dev_match) |=> $stable(regs));
    // R7: the file is frozen while a read transfer runs
    p_no_write_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> $stable(regs));
endmodule

// File: tb/sim_sir_ctrl_port.sv
module sim_sir_ctrl_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_din = 1'b0, ser_strobe = 1'b0;
    logic [1:0] dev_strap = 2'd1;
    logic       ser_dout, inclamp_pol, blkclamp_pol, samp_pol, odd_first, standby;
    logic       test_en, test_stripe;
    logic [1:0] out_dly, test_interval;
    logic [9:0] gain_even, gain_odd;
    logic [7:0] black_even, black_odd;

    int n_chk = 0, n_bad = 0;
    logic [9:0] model [8];

    always #5 clk = ~clk;

    sir_ctrl_port u0 (.*);

    function automatic logic [9:0] keep_bits(input int r);
        case (r)
            0: return 10'b0011010111;
            1: return 10'b0000000001;
            2, 3: return 10'b1111111111;
            4, 5: return 10'b0011111111;
            6: return 10'b0000110101;
            default: return 10'b0;
        endcase
    endfunction

    function automatic logic [9:0] port_reg(input int r);
        case (r)
            0: return {2'b0, out_dly, 1'b0, odd_first, 1'b0, samp_pol, blkclamp_pol, inclamp_pol};
            1: return {9'b0, standby};
            2: return gain_even;
            3: return gain_odd;
            4: return {2'b0, black_even};
            5: return {2'b0, black_odd};
            6: return {4'b0, test_interval, 1'b0, test_stripe, 1'b0, test_en};
            default: return 10'b0;
        endcase
    endfunction

    task automatic model_reset();
        for (int r = 0; r < 8; r++) model[r] = 10'd0;
        model[2] = 10'd64; model[3] = 10'd64; model[4] = 10'd80; model[5] = 10'd80;
    endtask

    task automatic chk(input logic [9:0] got, input logic [9:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < 7; r++) chk(port_reg(r), model[r], tag);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        ser_din = b; ser_clk = 1'b1; tick(2);
        ser_clk = 1'b0; tick(2);
    endtask

    task automatic strobe();
        ser_strobe = 1'b1; tick(2);
        ser_strobe = 1'b0; tick(2);
    endtask

    task automatic send(input logic [15:0] f, input int junk);
        for (int i = 0; i < junk; i++) clk_bit(1'($urandom));
        for (int i = 15; i >= 0; i--) clk_bit(f[i]);
        strobe();
    endtask

    // model update for a frame that reached an idle port
    task automatic apply(input logic [15:0] f);
        if (f[15:14] == dev_strap && !f[13] && f[12:10] != 3'd7)
            model[f[12:10]] = f[9:0] & keep_bits(int'(f[12:10]));
    endtask

    task automatic collect(input logic [9:0] exp, input logic active, input string tag);
        for (int k = 9; k >= 0; k--) begin
            chk({9'b0, ser_dout}, active ? {9'b0, exp[k]} : 10'd0, tag);
            clk_bit(1'($urandom));
        end
        chk({9'b0, ser_dout}, 10'd0, {tag, " R10 after transfer"});
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] f, w;
        void'($urandom(32'd1234));
        model_reset();
        tick(3);
        check_regs("R5 reset values");
        chk({9'b0, ser_dout}, 10'd0, "R10 idle after reset");
        rst_n = 1'b1;
        tick(2);

        // R4 field positions: config with every bit set, then read back (R9)
        f = {2'd1, 1'b0, 3'd0, 10'h3FF}; send(f, 0); apply(f);
        check_regs("R4 config write");
        send({2'd1, 1'b1, 3'd0, 10'h000}, 0);
        collect(10'h0D7, 1'b1, "R9 config readback");
        f = {2'd1, 1'b0, 3'd6, 10'h3FF}; send(f, 0); apply(f);
        check_regs("R4 test register");
        f = {2'd1, 1'b0, 3'd3, 10'h3FF}; send(f, 0); apply(f);
        check_regs("R4 odd gain full scale");

        // R4 reserved register write, R9 reserved register read
        send({2'd1, 1'b0, 3'd7, 10'h3FF}, 0);
        check_regs("R4 reserved write no effect");
        send({2'd1, 1'b1, 3'd7, 10'h000}, 0);
        collect(10'h000, 1'b1, "R9 reserved register reads zero");

        // R3 foreign device write
        send({2'd2, 1'b0, 3'd2, 10'h2AA}, 0);
        check_regs("R3 mismatched write ignored");
        // R8 foreign device read
        send({2'd0, 1'b1, 3'd2, 10'h000}, 0);
        collect(10'h000, 1'b0, "R8 mismatched read silent");

        // R2 extra leading bits
        f = {2'd1, 1'b0, 3'd4, 10'h0C3}; send(f, 5); apply(f);
        check_regs("R2 last sixteen bits used");

        // R7 write frame built up during a read, strobed before the end
        w = {2'd1, 1'b0, 3'd2, 10'h155};
        send({2'd1, 1'b1, 3'd4, 3'b000, w[15:9]}, 0);
        for (int j = 0; j < 9; j++) begin
            chk({9'b0, ser_dout}, {9'b0, model[4][9-j]}, "R6 read during build");
            clk_bit(w[8-j]);
        end
        strobe();
        check_regs("R7 write during read ignored");
        chk({9'b0, ser_dout}, {9'b0, model[4][0]}, "R7 transfer continues");
        clk_bit(1'b0);
        chk({9'b0, ser_dout}, 10'd0, "R6 ends after ten bits");
        send(w, 0); apply(w);
        check_regs("R1 write after read");

        // strap change
        dev_strap = 2'd3;
        f = {2'd3, 1'b0, 3'd5, 10'h0FE}; send(f, 0); apply(f);
        check_regs("R3 new strap accepted");

        // random mix
        for (int it = 0; it < 70; it++) begin
            f[15:14] = ($urandom % 4 == 0) ? 2'($urandom) : dev_strap;
            f[13]    = ($urandom % 4 == 0);
            f[12:10] = 3'($urandom);
            f[9:0]   = 10'($urandom);
            send(f, int'($urandom % 3));
            if (f[13]) begin
                if (f[15:14] == dev_strap) collect(model[f[12:10]], 1'b1, "R6 random read");
                else                       collect(10'h000, 1'b0, "R8 random read");
            end else begin
                apply(f);
                check_regs("R1 random write");
            end
        end

        // R11 asynchronous reset between edges
        @(negedge clk); #2;
        rst_n = 1'b0; #1;
        model_reset();
        check_regs("R11 async reset");
        tick(2);
        rst_n = 1'b1;
        tick(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule